// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block turns eight synchronized pin inputs into up to eight sum-of-products match signals. Eight bit slices each pick one input channel and test it against one of eight conditions: a level, an edge that is remembered until used, a one-cycle edge event, or a fixed true or false value. Slices are ANDed in order into a product term. A term is closed at a slice that carries an end flag, and the last slice always closes a term. Each closing slice drives its own interrupt line while its term holds. An optional receive-event pulse marks the moment the OR of all terms goes true.

Software sets the engine up through a small word-wide register port with three registers: control, channel select and condition. The engine state can also be read back through the top byte of the control register.

Top module: `pm_engine`

## Requirements
- R1: After a synchronous active-low reset, all three registers read zero, every interrupt line is low and the event output is low.
- R2: Reads mask the reserved bits to zero. Control (address 0) keeps only bits 1:0, bits 23:2 read 0 and bits 31:24 are the term-state byte. The select register (address 1) holds bits 31:8. The condition register (address 2) holds bits 31:8 and 6:0, and bit 7 reads 0. Address 3 reads 0.
- R3: Slice i uses the channel select at bits 8+3i+2:8+3i of address 1 and the condition code at the same bits of address 2. Code 4 matches while the chosen pin is high. Code 5 matches while it is low.
- R4: Codes 1 (rise), 2 (fall) and 3 (either edge) are sticky. An edge is found by comparing the pin with its value one clock earlier, and that history is all low after reset. Once the edge is seen, the slice stays matched afterwards.
- R5: Code 0 always matches. Code 6 never matches.
- R6: Code 7 matches only in the cycle in which the chosen pin changes. It keeps nothing.
- R7: Bit i (i = 0..6) of address 2 marks slice i as the end of a term, and slice 7 always ends one. A term is the AND of all slices after the previous end, up to and including its own end slice.
- R8: Control bit 0 enables the interrupts. Interrupt line i is high one clock after the cycle in which bit 0 was set and the term ending at slice i was true. Lines for slices that do not end a term stay low.
- R9: When control bit 1 is set, the event output is high for exactly one clock after a cycle in which the OR of all terms is true and was false in the cycle before.
- R10: A sticky slice clears when its term is true (the match is consumed), and also when address 1 or 2 is written. The clear wins over an edge in the same cycle.
- R11: Control bits 31:24 show, one clock late, the value of each slice's term. This is independent of control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronized pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 select, 2 condition) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| match_irq | output | 8 | Per-slice term interrupt lines |
| rx_event | output | 1 | One-clock pulse when the OR of terms rises |

## Verification
The assertions check on every cycle that the event pulse never lasts two clocks and never appears without its enable. They also check that the interrupt lines stay low while the enable bit was clear, that a sticky slice only sets after an edge was seen, and that every clear request empties it. The sticky behaviour depends on history, so the bench scenarios have to show it. They show an edge held across a level change, consumption by a true term, loss on a register rewrite, a one-cycle event, and the grouping of slices into terms by end flags. They also show reserved-bit masking and the term byte in the control readback. A behavioural model compared every clock covers random pin and configuration traffic.

// File: rtl/pm_pkg.sv
// Shared constants and the condition code type of the pattern match engine.
package pm_pkg;
    localparam int SLICES    = 8;
    localparam int CH_W      = $clog2(SLICES);
    localparam int DATA_W    = 32;
    localparam int FIELD_LSB = 8;

    typedef enum logic [2:0] {
        COND_ALWAYS = 3'd0,
        COND_RISE   = 3'd1,
        COND_FALL   = 3'd2,
        COND_EDGE   = 3'd3,
        COND_HIGH   = 3'd4,
        COND_LOW    = 3'd5,
        COND_NEVER  = 3'd6,
        COND_EVENT  = 3'd7
    } cond_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SRC  = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;
endpackage

// File: rtl/pm_regs.sv
// Register file: control, per-slice channel select, per-slice condition and end flags.
// Assumes FIELD_LSB + SLICES*CH_W == DATA_W and SLICES + 2 <= FIELD_LSB + SLICES... (8 slices of 3 bits).
module pm_regs
    import pm_pkg::*;
#(
    parameter int N  = SLICES,
    parameter int CW = CH_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    input  logic [N-1:0]     term_state,
    output logic [DW-1:0]    rdata,
    output logic             sel_en,
    output logic             rx_en,
    output logic [N*CW-1:0]  chan_sel,
    output logic [N*3-1:0]   cond_sel,
    output logic [N-1:0]     endpt,
    output logic             cfg_wr
);
    localparam int FW    = N * CW;
    localparam int CTL_Z = DW - N - 2;

    logic [1:0]    ctrl_q;
    logic [FW-1:0] src_q;
    logic [N*3-1:0] cond_q;
    logic [N-2:0]  ep_q;
    logic          reg_unused;

    assign reg_unused = wdata[FIELD_LSB-1];

    // Register writes with reserved bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            src_q  <= '0;
            cond_q <= '0;
            ep_q   <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: ctrl_q <= wdata[1:0];
                ADDR_SRC:  src_q  <= wdata[DW-1:FIELD_LSB];
                ADDR_CFG: begin
                    cond_q <= wdata[DW-1:FIELD_LSB];
                    ep_q   <= wdata[N-2:0];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer with reserved bits as zero
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {term_state, {CTL_Z{1'b0}}, ctrl_q};
            ADDR_SRC:  rdata = {src_q, {FIELD_LSB{1'b0}}};
            ADDR_CFG:  rdata = {cond_q, 1'b0, ep_q};
            default:   rdata = '0;
        endcase
    end

    assign sel_en   = ctrl_q[0];
    assign rx_en    = ctrl_q[1];
    assign chan_sel = src_q;
    assign cond_sel = cond_q;
    assign endpt    = {1'b1, ep_q};
    assign cfg_wr   = we && (addr == ADDR_SRC || addr == ADDR_CFG);
endmodule

// File: rtl/pm_slice.sv
// One bit slice: selects a channel, evaluates its condition, keeps the sticky edge flag.
// Assumes rise/fall vectors are one-cycle edge indications for all channels.
module pm_slice
    import pm_pkg::*;
#(
    parameter int N  = SLICES,
    parameter int CW = CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pins,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  fall,
    input  logic [CW-1:0] chan,
    input  logic [2:0]    cond,
    input  logic          clr,
    output logic          match
);
    logic lvl, r, f, edge_hit, sticky_q;
    cond_e code;

    assign code = cond_e'(cond);
    assign lvl  = pins[chan];
    assign r    = rise[chan];
    assign f    = fall[chan];

    // Edge seen this cycle for the sticky codes
    always_comb begin
        case (code)
            COND_RISE: edge_hit = r;
            COND_FALL: edge_hit = f;
            COND_EDGE: edge_hit = r | f;
            default:   edge_hit = 1'b0;
        endcase
    end

    // Sticky flag: clear has priority over a new edge
    always_ff @(posedge clk) begin
        if (!rst_n)        sticky_q <= 1'b0;
        else if (clr)      sticky_q <= 1'b0;
        else if (edge_hit) sticky_q <= 1'b1;
    end

    // Slice match value
    always_comb begin
        case (code)
            COND_ALWAYS: match = 1'b1;
            COND_RISE,
            COND_FALL,
            COND_EDGE:   match = sticky_q | edge_hit;
            COND_HIGH:   match = lvl;
            COND_LOW:    match = ~lvl;
            COND_NEVER:  match = 1'b0;
            default:     match = r | f;
        endcase
    end

    // R4
    // sticky_set_chk
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q) |-> $past(edge_hit));
    // R10
    // sticky_clr_chk
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> !sticky_q);
endmodule

// File: rtl/pm_combine.sv
// Chains slice matches into product terms closed by end flags; reports per-slice consumption.
// Assumes endpt[N-1] is 1 so every slice belongs to a term.
module pm_combine
    import pm_pkg::*;
#(
    parameter int N = SLICES
) (
    input  logic [N-1:0] match,
    input  logic [N-1:0] endpt,
    output logic [N-1:0] term,
    output logic [N-1:0] consumed
);
    // Running AND, emitted and restarted at each end slice
    always_comb begin
        logic acc;
        acc  = 1'b1;
        term = '0;
        for (int j = 0; j < N; j++) begin
            acc = acc & match[j];
            if (endpt[j]) begin
                term[j] = acc;
                acc     = 1'b1;
            end
        end
    end

    // Each slice inherits the value of the term that owns it
    always_comb begin
        logic own;
        own      = 1'b0;
        consumed = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (endpt[j]) own = term[j];
            consumed[j] = own;
        end
    end
endmodule

// File: rtl/pm_engine.sv
// Top of the bit-slice pattern match engine: edge detection, slice array, term
// combination, registered interrupt lines and the receive-event pulse.
// Assumes pin_i is already synchronized to clk.
module pm_engine
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLICES-1:0] pin_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SLICES-1:0] match_irq,
    output logic              rx_event
);
    logic [SLICES-1:0]      pin_q, rise, fall, match, term, consumed, term_q, endpt;
    logic [SLICES*CH_W-1:0] chan_sel;
    logic [SLICES*3-1:0]    cond_sel;
    logic                   sel_en, rx_en, cfg_wr, rx_q;

    pm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .term_state(term_q), .rdata(reg_rdata), .sel_en(sel_en), .rx_en(rx_en),
        .chan_sel(chan_sel), .cond_sel(cond_sel), .endpt(endpt), .cfg_wr(cfg_wr)
    );

    // Pin history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_i;
    end

    assign rise = pin_i & ~pin_q;
    assign fall = ~pin_i & pin_q;

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        pm_slice u_slice (
            .clk(clk), .rst_n(rst_n), .pins(pin_i), .rise(rise), .fall(fall),
            .chan(chan_sel[i*CH_W +: CH_W]), .cond(cond_sel[i*3 +: 3]),
            .clr(cfg_wr | consumed[i]), .match(match[i])
        );
    end

    pm_combine u_comb (.match(match), .endpt(endpt), .term(term), .consumed(consumed));

    // Registered term state, gated interrupts and event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q    <= '0;
            match_irq <= '0;
            rx_q      <= 1'b0;
        end else begin
            term_q    <= term;
            match_irq <= sel_en ? term : '0;
            rx_q      <= rx_en & (|term) & ~(|term_q);
        end
    end

    assign rx_event = rx_q;

    // R9
    // rx_single_chk
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);
    // R9
    // rx_enable_chk
    rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> $past(rx_en));
    // R8
    // irq_gate_chk
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_en) |-> (match_irq == '0));
endmodule

// File: tb/pm_engine_tb.sv
module pm_engine_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  match_irq;
    logic        rx_event;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_pin_q = '0, m_term_q = '0, m_irq = '0;
    bit          m_st[8];
    bit          m_rx = 1'b0;
    logic [1:0]  m_ctrl = '0;
    logic [23:0] m_src = '0, m_cond = '0;
    logic [6:0]  m_ep = '0;
    logic [7:0]  cur_pins = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_irq(match_irq), .rx_event(rx_event)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_term_q, 22'd0, m_ctrl};
            2'd1: return {m_src, 8'd0};
            2'd2: return {m_cond, 1'b0, m_ep};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] mk_src(input int s[8]);
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) v[8+3*i +: 3] = s[i][2:0];
        return v;
    endfunction

    function automatic logic [31:0] mk_cfg(input int c[8], input logic [6:0] ep);
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) v[8+3*i +: 3] = c[i][2:0];
        v[6:0] = ep;
        return v;
    endfunction

    // One clock: drive inputs, advance the model, compare after the edge
    task automatic step(input logic [7:0] p, input bit we, input logic [1:0] a, input logic [31:0] d);
        bit mt[8], hit[8], own[8];
        logic [7:0] term = '0;
        int start = 0;
        pin_i = p; reg_we = we; reg_addr = a; reg_wdata = d; cur_pins = p;
        for (int i = 0; i < 8; i++) begin
            int ch = int'(m_src[3*i +: 3]);
            int cd = int'(m_cond[3*i +: 3]);
            bit lv = p[ch];
            bit r = lv && !m_pin_q[ch];
            bit f = !lv && m_pin_q[ch];
            hit[i] = (cd == 1 && r) || (cd == 2 && f) || (cd == 3 && (r || f));
            case (cd)
                0: mt[i] = 1;
                1, 2, 3: mt[i] = m_st[i] || hit[i];
                4: mt[i] = lv;
                5: mt[i] = !lv;
                6: mt[i] = 0;
                default: mt[i] = r || f;
            endcase
        end
        for (int j = 0; j < 8; j++) begin
            if (j == 7 || m_ep[j]) begin
                bit all = 1;
                for (int k = start; k <= j; k++) all = all && mt[k];
                term[j] = all;
                for (int k = start; k <= j; k++) own[k] = all;
                start = j + 1;
            end
        end
        for (int i = 0; i < 8; i++) begin
            if ((we && (a == 2'd1 || a == 2'd2)) || own[i]) m_st[i] = 0;
            else if (hit[i]) m_st[i] = 1;
        end
        m_rx = m_ctrl[1] && (term != 0) && (m_term_q == 0);
        m_irq = m_ctrl[0] ? term : 8'h00;
        m_term_q = term;
        m_pin_q = p;
        if (we) begin
            case (a)
                2'd0: m_ctrl = d[1:0];
                2'd1: m_src = d[31:8];
                2'd2: begin m_cond = d[31:8]; m_ep = d[6:0]; end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk("MODEL irq", {24'd0, match_irq}, {24'd0, m_irq});
        chk("MODEL rxev", {31'd0, rx_event}, {31'd0, m_rx});
        chk("MODEL rdata", reg_rdata, exp_rd(a));
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        step(cur_pins, 1'b1, a, d);
    endtask

    task automatic drive(input logic [7:0] p);
        step(p, 1'b0, 2'd0, 32'd0);
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0); chk("R1 ctrl", reg_rdata, 32'd0);
        rd(2'd1); chk("R1 src", reg_rdata, 32'd0);
        rd(2'd2); chk("R1 cfg", reg_rdata, 32'd0);
        chk("R1 irq", {24'd0, match_irq}, 32'd0);
        chk("R1 rxev", {31'd0, rx_event}, 32'd0);
        reg_addr = 2'd0;
        rst_n = 1'b1;
        drive(8'h00);

        // R2 reserved bits
        wreg(2'd0, 32'hFFFF_FFFF); rd(2'd0); chk("R2 ctrl", reg_rdata & 32'h00FF_FFFF, 32'h0000_0003);
        wreg(2'd1, 32'hFFFF_FFFF); rd(2'd1); chk("R2 src", reg_rdata, 32'hFFFF_FF00);
        wreg(2'd2, 32'hFFFF_FFFF); rd(2'd2); chk("R2 cfg", reg_rdata, 32'hFFFF_FF7F);
        rd(2'd3); chk("R2 addr3", reg_rdata, 32'd0);
        wreg(2'd0, 32'd1);

        // R3 level codes
        wreg(2'd1, mk_src('{2, 0, 0, 0, 0, 0, 0, 0}));
        wreg(2'd2, mk_cfg('{4, 6, 6, 6, 6, 6, 6, 6}, 7'h01));
        drive(8'h04); chk("R3 high", {24'd0, match_irq}, 32'h01);
        drive(8'h00); chk("R3 high off", {24'd0, match_irq}, 32'h00);
        wreg(2'd2, mk_cfg('{5, 6, 6, 6, 6, 6, 6, 6}, 7'h01));
        drive(8'h00); chk("R3 low", {24'd0, match_irq}, 32'h01);
        drive(8'h04); chk("R3 low off", {24'd0, match_irq}, 32'h00);

        // R4 sticky rise chained with a level (R7), consumed (R10)
        wreg(2'd1, mk_src('{2, 3, 0, 0, 0, 0, 0, 0}));
        wreg(2'd2, mk_cfg('{1, 4, 6, 6, 6, 6, 6, 6}, 7'h02));
        drive(8'h00);
        drive(8'h04); chk("R4 rise alone", {24'd0, match_irq}, 32'h00);
        drive(8'h00); chk("R4 held", {24'd0, match_irq}, 32'h00);
        drive(8'h08); chk("R4 sticky term", {24'd0, match_irq}, 32'h02);
        drive(8'h08); chk("R10 consumed", {24'd0, match_irq}, 32'h00);

        // R10 rewrite clears sticky
        drive(8'h00);
        drive(8'h04);
        wreg(2'd1, mk_src('{2, 3, 0, 0, 0, 0, 0, 0}));
        drive(8'h0C); chk("R10 write clear", {24'd0, match_irq}, 32'h00);

        // R6 event code
        wreg(2'd1, mk_src('{4, 0, 0, 0, 0, 0, 0, 0}));
        wreg(2'd2, mk_cfg('{7, 6, 6, 6, 6, 6, 6, 6}, 7'h01));
        drive(8'h00);
        drive(8'h10); chk("R6 rise event", {24'd0, match_irq}, 32'h01);
        drive(8'h10); chk("R6 no hold", {24'd0, match_irq}, 32'h00);
        drive(8'h00); chk("R6 fall event", {24'd0, match_irq}, 32'h01);
        drive(8'h00); chk("R6 quiet", {24'd0, match_irq}, 32'h00);

        // R5 constants, R7 slice 7 ends a term
        wreg(2'd1, 32'd0);
        wreg(2'd2, mk_cfg('{0, 0, 0, 0, 0, 0, 0, 0}, 7'h00));
        drive(8'h00); chk("R5 always", {24'd0, match_irq}, 32'h80);
        wreg(2'd2, mk_cfg('{0, 0, 0, 6, 0, 0, 0, 0}, 7'h00));
        drive(8'h00); chk("R5 never", {24'd0, match_irq}, 32'h00);
        wreg(2'd2, mk_cfg('{0, 0, 0, 0, 0, 0, 0, 0}, 7'h0A));
        drive(8'h00); chk("R7 terms", {24'd0, match_irq}, 32'h8A);

        // R8 gate off, R11 term byte
        wreg(2'd0, 32'd0);
        drive(8'h00); chk("R8 gated", {24'd0, match_irq}, 32'h00);
        rd(2'd0); chk("R11 term byte", reg_rdata, 32'h8A00_0000);

        // R9 event pulse
        wreg(2'd1, mk_src('{5, 0, 0, 0, 0, 0, 0, 0}));
        wreg(2'd2, mk_cfg('{4, 6, 6, 6, 6, 6, 6, 6}, 7'h01));
        wreg(2'd0, 32'd3);
        drive(8'h00);
        drive(8'h20); chk("R9 pulse", {31'd0, rx_event}, 32'd1);
        drive(8'h20); chk("R9 one clock", {31'd0, rx_event}, 32'd0);
        drive(8'h00);
        drive(8'h20); chk("R9 pulse again", {31'd0, rx_event}, 32'd1);
        drive(8'h00);
        wreg(2'd0, 32'd1);
        drive(8'h20); chk("R9 disabled", {31'd0, rx_event}, 32'd0);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] p = 8'($urandom);
            if ($urandom_range(0, 30) == 0)
                step(p, 1'b1, 2'($urandom_range(0, 3)), $urandom);
            else
                step(p, 1'b0, 2'($urandom_range(0, 3)), 32'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule